// File: doc/BRIEF.md
# Iterative Subtract-and-Minimum GCD Engine

This block finds the greatest common divisor of two unsigned operands, 16 bits wide by default, through repeated subtraction. Both operands are captured into a pair of state registers when a start strobe arrives. On every later clock edge the pair is replaced at once by its absolute difference and its smaller member. All of the step logic is combinational: one comparator, one subtractor and a few multiplexers. The loop ends when the two registers hold equal values or when either one is zero. The result is then kept in the first register, and a done flag marks it valid.

A controller with three states sequences the work. `ST_IDLE` is the state after reset. `ST_RUN` is the state while the loop iterates. `ST_DONE` holds the result. The named transitions are these. IDLE→RUN happens on start. RUN→RUN happens on each step, and also on a start that reloads the operands mid-run. RUN→DONE happens on termination. DONE→RUN happens on the next start. DONE→DONE holds the result while start is low. Every state returns to IDLE under reset. The select signal to the register multiplexers has four values: hold, load operands, take one step, and store the final value.

Top module: `gcd_iter`

## Requirements
- R1: A synchronous active-high reset drives `done_o` to 0 and `gcd_o` to 0 on the next clock edge, and the controller then waits in the idle state.
- R2: A clock edge that samples `start_i` high loads `opa_i`/`opb_i` into the state registers. `done_o` is 0 in the following cycle. Any computation in flight, or any result being held, is discarded.
- R3: Each clock edge in the run state without termination replaces the pair (x, y) with (|x−y|, min(x, y)). From the start edge, `done_o` therefore rises after exactly (number of such steps + 1) edges.
- R4: The loop terminates when the two register values are equal, and that value becomes the result.
- R5: If either captured operand is zero, the result is the other operand. A pair of zeros gives 0. In both cases `done_o` is high after the edge that follows the start edge.
- R6: While `done_o` is high and `start_i` stays low, `done_o` stays high and `gcd_o` does not change.
- R7: When `done_o` is high, `gcd_o` equals the greatest common divisor of the operands captured at the last start, with gcd(0,0)=0.
- R8: The number of edges from the start edge to the edge that raises `done_o` never exceeds max(a, b) + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Load operands and begin a new computation |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| gcd_o | output | WIDTH | Result, valid while `done_o` is high |
| done_o | output | 1 | Computation finished, result valid |

## Verification
Two situations are hard to reach from the ports. The first is a start strobe that lands while the loop is still far from terminating. The second is the worst-case iteration count. Both come from the operand pair (0xFFFF, 1), which needs tens of thousands of single-unit steps. The bench starts that pair, then restarts with a short pair partway through, and it also runs the pair to completion to meet the latency bound. Every operand pair from 0 to 15 is swept, so equal, zero, one and coprime operands all occur, each checked for exact latency and for a held result.

// File: rtl/gcd_iter_pkg.sv
package gcd_iter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } gcd_state_e;

    typedef enum logic [1:0] {
        SEL_HOLD,
        SEL_LOAD,
        SEL_STEP,
        SEL_FINAL
    } gcd_sel_e;

endpackage

// File: rtl/gcd_step.sv
module gcd_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic [WIDTH-1:0] diff_o,
    output logic [WIDTH-1:0] min_o,
    output logic [WIDTH-1:0] result_o,
    output logic             finish_o
);

    logic x_ge_y;
    logic x_zero;
    logic y_zero;

    always_comb begin
        x_ge_y   = (x_i >= y_i);
        x_zero   = (x_i == '0);
        y_zero   = (y_i == '0);
        diff_o   = x_ge_y ? (x_i - y_i) : (y_i - x_i);
        min_o    = x_ge_y ? y_i : x_i;
        finish_o = (x_i == y_i) || x_zero || y_zero;
        // equal values, one zero, or both zero: choose the non-zero side
        result_o = x_zero ? y_i : x_i;
    end

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_iter_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     finish_i,
    output gcd_sel_e sel_o,
    output logic     done_o
);

    gcd_state_e state_q;
    gcd_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN: begin
                if (start_i)       state_d = ST_RUN;
                else if (finish_i) state_d = ST_DONE;
                else               state_d = ST_RUN;
            end
            ST_DONE: if (start_i) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sel_o  = SEL_HOLD;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) sel_o = SEL_LOAD;
            end
            ST_RUN: begin
                if (start_i)       sel_o = SEL_LOAD;
                else if (finish_i) sel_o = SEL_FINAL;
                else               sel_o = SEL_STEP;
            end
            ST_DONE: begin
                done_o = 1'b1;
                if (start_i) sel_o = SEL_LOAD;
            end
            default: sel_o = SEL_HOLD;
        endcase
    end

endmodule

// File: rtl/gcd_iter.sv
module gcd_iter
    import gcd_iter_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0] gcd_o,
    output logic             done_o
);

    logic [WIDTH-1:0] x_q;
    logic [WIDTH-1:0] y_q;
    logic [WIDTH-1:0] diff;
    logic [WIDTH-1:0] minv;
    logic [WIDTH-1:0] result;
    logic             finish;
    gcd_sel_e         sel;

    gcd_step #(.WIDTH(WIDTH)) u_step (
        .x_i      (x_q),
        .y_i      (y_q),
        .diff_o   (diff),
        .min_o    (minv),
        .result_o (result),
        .finish_o (finish)
    );

    gcd_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .finish_i (finish),
        .sel_o    (sel),
        .done_o   (done_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else begin
            unique case (sel)
                SEL_LOAD: begin
                    x_q <= opa_i;
                    y_q <= opb_i;
                end
                SEL_STEP: begin
                    x_q <= diff;
                    y_q <= minv;
                end
                SEL_FINAL: begin
                    x_q <= result;
                    y_q <= result;
                end
                default: begin
                    x_q <= x_q;
                    y_q <= y_q;
                end
            endcase
        end
    end

    assign gcd_o = x_q;

endmodule

// File: rtl/gcd_iter_chk.sv
module gcd_iter_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [WIDTH-1:0] gcd_o,
    input logic             done_o
);

    localparam int CW = WIDTH + 2;

    logic [WIDTH-1:0] cap_a;
    logic [WIDTH-1:0] cap_b;
    logic [CW-1:0]    edge_cnt;
    logic             busy;
    logic [CW-1:0]    bound;
    logic             divides_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a    <= '0;
            cap_b    <= '0;
            edge_cnt <= '0;
            busy     <= 1'b0;
        end else if (start_i) begin
            cap_a    <= opa_i;
            cap_b    <= opb_i;
            edge_cnt <= '0;
            busy     <= 1'b1;
        end else if (busy) begin
            if (done_o) begin
                busy <= 1'b0;
            end else begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        bound = {2'b00, ((cap_a >= cap_b) ? cap_a : cap_b)} + 1'b1;
        if (gcd_o == '0) begin
            divides_ok = (cap_a == '0) && (cap_b == '0);
        end else begin
            divides_ok = ((cap_a % gcd_o) == '0) && ((cap_b % gcd_o) == '0);
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!done_o && gcd_o == '0));

    assert_start_drops_done_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !done_o);

    assert_zero_operand_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && opb_i == '0) ##1 !start_i |=> (done_o && gcd_o == $past(opa_i, 2)));

    assert_zero_first_R5: assert property (@(posedge clk) disable iff (rst)
        (start_i && opa_i == '0) ##1 !start_i |=> (done_o && gcd_o == $past(opb_i, 2)));

    assert_result_held_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(gcd_o)));

    assert_result_divides_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> divides_ok);

    assert_latency_bound_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> (edge_cnt <= bound));

endmodule

bind gcd_iter gcd_iter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .gcd_o   (gcd_o),
    .done_o  (done_o)
);

// File: tb/gcd_iter_bench.sv
module gcd_iter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 16;
    localparam int VEC_LIMIT  = 70000;
    localparam int WATCHDOG   = 190000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [WIDTH-1:0] opa_i = '0;
    logic [WIDTH-1:0] opb_i = '0;
    logic [WIDTH-1:0] gcd_o;
    logic             done_o;

    int n_checks = 0;
    int n_fails  = 0;

    gcd_iter #(.WIDTH(WIDTH)) u_gcd_iter (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .gcd_o   (gcd_o),
        .done_o  (done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic int ref_gcd(input int a, input int b);
        int p = a;
        int q = b;
        while (q != 0) begin
            int r = p % q;
            p = q;
            q = r;
        end
        return p;
    endfunction

    function automatic int ref_steps(input int a, input int b);
        int x = a;
        int y = b;
        int s = 0;
        while (x != y && x != 0 && y != 0) begin
            int d = (x >= y) ? x - y : y - x;
            int m = (x >= y) ? y : x;
            x = d;
            y = m;
            s++;
        end
        return s;
    endfunction

    task automatic run_vec(input int a, input int b);
        int n = 0;
        int exp_g = ref_gcd(a, b);
        int exp_n = ref_steps(a, b) + 1;
        int mx = (a >= b) ? a : b;
        int held;
        @(negedge clk);
        start_i = 1'b1;
        opa_i = WIDTH'(a);
        opb_i = WIDTH'(b);
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0, "R2 done low after start", int'(done_o), 0);
        while (!done_o && n < VEC_LIMIT) begin
            @(negedge clk);
            n++;
        end
        check(int'(gcd_o) == exp_g, "R7 gcd value", int'(gcd_o), exp_g);
        check(n == exp_n, "R3 edges to done", n, exp_n);
        check(n <= mx + 1, "R8 latency bound", n, mx + 1);
        if (a == b)
            check(int'(gcd_o) == a, "R4 equal operands", int'(gcd_o), a);
        if (a == 0 || b == 0) begin
            check(int'(gcd_o) == (a | b), "R5 zero operand result", int'(gcd_o), a | b);
            check(n == 1, "R5 zero operand latency", n, 1);
        end
        held = int'(gcd_o);
        repeat (3) @(negedge clk);
        check(done_o == 1'b1, "R6 done held", int'(done_o), 1);
        check(int'(gcd_o) == held, "R6 result held", int'(gcd_o), held);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        check(gcd_o == '0, "R1 gcd after reset", int'(gcd_o), 0);

        // R3 R4 R5 R7: every pair of small operands
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_vec(a, b);
            end
        end

        // corner pairs: coprime, one, all-ones
        run_vec(48, 18);
        run_vec(1000, 999);
        run_vec(17, 1);
        run_vec(65535, 65535);
        run_vec(65535, 65280);
        run_vec(0, 65535);
        run_vec(40503, 24079);

        // R2: restart in the middle of a long computation
        @(negedge clk);
        start_i = 1'b1;
        opa_i = 16'hFFFF;
        opb_i = 16'h0001;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        check(done_o == 1'b0, "R2 still running before restart", int'(done_o), 0);
        run_vec(18, 12);

        // R8: worst-case iteration count
        run_vec(65535, 1);

        // R1: reset while a result is held
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(done_o == 1'b0, "R1 done cleared from held result", int'(done_o), 0);
        check(gcd_o == '0, "R1 gcd cleared from held result", int'(gcd_o), 0);
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R1 idle without start", int'(done_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule